// File: doc/BRIEF.md
# Panel Timing and Polarity Generator

This block derives the panel's own pixel and line position from incoming video timing and builds the control strobes a flat panel needs from it. A static strap chooses the input timing source. In data-enable mode, line starts come from rising edges of the data-enable input. A data-enable rise that follows a long idle gap marks the top of a frame. In sync-only mode, line starts come from horizontal sync rises. Vertical sync marks the next line as the first line of a frame.

Between input line starts, the counters keep running as a flywheel over the programmed total line and frame sizes. When the input stays silent for too long, the block declares loss and runs on its internal timing alone. After power-on reset it also starts in this free-running state, at pixel 0 of line 0. It locks back to the input only after two line starts with no timeout between them.

From the counters the block drives a panel data-enable, a polarity-reversal output and a bank of general-purpose windowed outputs. The polarity-reversal output flips every line or every second line and also alternates from frame to frame. Each windowed output covers a programmable rectangle of lines and pixels and serves as a column latch pulse or a row driver control. The parameters size the counters for active areas of up to 800 dual pixels by 1200 lines (1600x1200 at two pixels per clock).

Top module: `panel_timing_gen`

## Requirements
- R1: While rst_ni is low and right after its release, px_o = 0, ln_o = 0, free_run_o = 1 and rev_o = 0 (with inv2_i low).
- R2: On a cycle without an accepted alignment, px_o advances by 1. From H_TOTAL-1 it wraps to 0 and ln_o advances by 1. ln_o wraps from V_TOTAL-1 to 0.
- R3: With sync_mode_i = 0 a line start is a rising edge of de_i. An accepted line start sets px_o to 0 one cycle later. It sets ln_o to 0 if the edge came at least VBLANK_MIN clocks after the previous line start, and to ln_o+1 (wrapping) otherwise.
- R4: With sync_mode_i = 1 a line start is a rising edge of hs_i. The first line start at or after a rising edge of vs_i sets ln_o to 0. Any other accepted line start sets ln_o to ln_o+1 (wrapping) and px_o to 0.
- R5: When LOSS_CLKS clocks pass with no line start, free_run_o goes high on the following cycle and stays high.
- R6: In free-run, line starts leave the counters untouched except for the second consecutive one with no timeout in between. That line start clears free_run_o and aligns the counters as in R3/R4.
- R7: With inv2_i = 0, rev_o = frame_polarity XOR ln_o[0].
- R8: With inv2_i = 1, rev_o = frame_polarity XOR ln_o[1].
- R9: frame_polarity starts at 0 and inverts whenever a line start moves ln_o to 0, whether by wrap or by alignment.
- R10: gpo_o[k] is high exactly when ln_o lies within the inclusive line range of window k and px_o lies within its inclusive pixel range. A window whose start exceeds its end is never high.
- R11: de_o is high exactly when px_o < H_ACTIVE and ln_o < V_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dual-pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_mode_i | input | 1 | Strap: 0 data-enable timing, 1 sync-only timing |
| inv2_i | input | 1 | 0 flips polarity every line, 1 every second line |
| de_i | input | 1 | Incoming data enable |
| hs_i | input | 1 | Incoming horizontal sync, active high |
| vs_i | input | 1 | Incoming vertical sync, active high |
| gpo_ln_first_i | input | N_GPO*LNW | First line of each window |
| gpo_ln_last_i | input | N_GPO*LNW | Last line of each window |
| gpo_px_first_i | input | N_GPO*PXW | First pixel of each window |
| gpo_px_last_i | input | N_GPO*PXW | Last pixel of each window |
| de_o | output | 1 | Panel data enable |
| px_o | output | PXW | Pixel position within the line |
| ln_o | output | LNW | Line position within the frame |
| rev_o | output | 1 | Polarity reversal |
| free_run_o | output | 1 | Internal timing in use |
| gpo_o | output | N_GPO | Windowed general-purpose outputs |

## Verification
A misaligned counter shows on px_o and ln_o one cycle after the line start that should have realigned it, and de_o and every window output shift with it. A wrong loss or lock state shows as free_run_o switching one cycle too early or too late. It also shows as px_o continuing to count through a line start it should have obeyed, or snapping to 0 on one it should have ignored. A frame polarity that misses a toggle leaves rev_o inverted for the whole following frame in both inversion modes. So a per-clock comparison catches it at the first cycle of that frame.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic {
    MODE_DE   = 1'b0,
    MODE_SYNC = 1'b1
  } ptg_mode_e;

  typedef struct packed {
    logic line;   // input line start seen
    logic frame;  // line start is also first line of frame
    logic align;  // counters must follow this line start
  } ptg_evt_t;
endpackage

// File: rtl/ptg_activity.sv
module ptg_activity
  import ptg_pkg::*;
#(
  parameter int LOSS_CLKS  = 80,
  parameter int VBLANK_MIN = 24,
  localparam int IW = $clog2(LOSS_CLKS + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ptg_mode_e mode_i,
  input  logic      de_i,
  input  logic      hs_i,
  input  logic      vs_i,
  output ptg_evt_t  evt_o,
  output logic      free_run_o
);
  logic          de_q, hs_q, vs_q, vs_pend_q;
  logic [IW-1:0] idle_q;
  logic [1:0]    good_q;
  logic          free_q;
  logic          de_rise, hs_rise, vs_rise;
  logic          line_ev, frame_ev, timeout;

  assign de_rise = de_i & ~de_q;
  assign hs_rise = hs_i & ~hs_q;
  assign vs_rise = vs_i & ~vs_q;
  assign timeout = (idle_q == IW'(LOSS_CLKS));

  always_comb begin
    if (mode_i == MODE_SYNC) begin
      line_ev  = hs_rise;
      frame_ev = hs_rise & (vs_pend_q | vs_rise);
    end else begin
      line_ev  = de_rise;
      frame_ev = de_rise & (idle_q >= IW'(VBLANK_MIN));
    end
  end

  assign evt_o.line  = line_ev;
  assign evt_o.frame = frame_ev;
  assign evt_o.align = line_ev & (~free_q | (good_q == 2'd1));
  assign free_run_o  = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q      <= 1'b0;
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      vs_pend_q <= 1'b0;
      idle_q    <= '0;
      good_q    <= '0;
      free_q    <= 1'b1;
    end else begin
      de_q      <= de_i;
      hs_q      <= hs_i;
      vs_q      <= vs_i;
      vs_pend_q <= (vs_pend_q | vs_rise) & ~hs_rise;
      if (line_ev) begin
        idle_q <= '0;
        if (good_q != 2'd2) good_q <= good_q + 2'd1;
        if (free_q && good_q == 2'd1) free_q <= 1'b0;
      end else if (timeout) begin
        free_q <= 1'b1;
        good_q <= '0;
      end else begin
        idle_q <= idle_q + IW'(1);
      end
    end
  end

  assert_loss_sets_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout && !line_ev) |=> free_run_o);

  assert_first_edge_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_run_o && good_q == 2'd0 && line_ev) |=> (free_run_o && !evt_o.align));

  assert_idle_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= IW'(LOSS_CLKS));
endmodule

// File: rtl/ptg_counters.sv
module ptg_counters
  import ptg_pkg::*;
#(
  parameter int H_TOTAL = 16,
  parameter int V_TOTAL = 9,
  localparam int PXW = $clog2(H_TOTAL),
  localparam int LNW = $clog2(V_TOTAL)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ptg_evt_t       evt_i,
  output logic [PXW-1:0] px_o,
  output logic [LNW-1:0] ln_o,
  output logic           fpol_o
);
  localparam logic [PXW-1:0] PX_LAST = PXW'(H_TOTAL - 1);
  localparam logic [LNW-1:0] LN_LAST = LNW'(V_TOTAL - 1);

  logic [PXW-1:0] px_q, px_d;
  logic [LNW-1:0] ln_q, ln_d, ln_inc;
  logic           fpol_q, new_line;

  assign ln_inc = (ln_q == LN_LAST) ? '0 : ln_q + LNW'(1);

  always_comb begin
    px_d     = px_q + PXW'(1);
    ln_d     = ln_q;
    new_line = 1'b0;
    if (evt_i.align) begin
      px_d     = '0;
      ln_d     = evt_i.frame ? '0 : ln_inc;
      new_line = 1'b1;
    end else if (px_q == PX_LAST) begin
      px_d     = '0;
      ln_d     = ln_inc;
      new_line = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q   <= '0;
      ln_q   <= '0;
      fpol_q <= 1'b0;
    end else begin
      px_q <= px_d;
      ln_q <= ln_d;
      if (new_line && ln_d == '0) fpol_q <= ~fpol_q;
    end
  end

  assign px_o   = px_q;
  assign ln_o   = ln_q;
  assign fpol_o = fpol_q;

  assert_px_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_q <= PX_LAST);

  assert_ln_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_q <= LN_LAST);

  assert_align_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.align |=> (px_q == '0));

  assert_frame_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ln_q != '0) ##1 (ln_q == '0) |-> (fpol_q != $past(fpol_q)));
endmodule

// File: rtl/ptg_window.sv
module ptg_window #(
  parameter int PXW = 4,
  parameter int LNW = 4
) (
  input  logic [PXW-1:0] px_i,
  input  logic [LNW-1:0] ln_i,
  input  logic [LNW-1:0] ln_first_i,
  input  logic [LNW-1:0] ln_last_i,
  input  logic [PXW-1:0] px_first_i,
  input  logic [PXW-1:0] px_last_i,
  output logic           hit_o
);
  logic in_ln, in_px;
  assign in_ln = (ln_i >= ln_first_i) && (ln_i <= ln_last_i);
  assign in_px = (px_i >= px_first_i) && (px_i <= px_last_i);
  assign hit_o = in_ln & in_px;
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import ptg_pkg::*;
#(
  parameter int H_ACTIVE   = 10,
  parameter int H_TOTAL    = 16,
  parameter int V_ACTIVE   = 6,
  parameter int V_TOTAL    = 9,
  parameter int VBLANK_MIN = 24,
  parameter int LOSS_CLKS  = 80,
  parameter int N_GPO      = 4,
  localparam int PXW = $clog2(H_TOTAL),
  localparam int LNW = $clog2(V_TOTAL)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_mode_i,
  input  logic                      inv2_i,
  input  logic                      de_i,
  input  logic                      hs_i,
  input  logic                      vs_i,
  input  logic [N_GPO-1:0][LNW-1:0] gpo_ln_first_i,
  input  logic [N_GPO-1:0][LNW-1:0] gpo_ln_last_i,
  input  logic [N_GPO-1:0][PXW-1:0] gpo_px_first_i,
  input  logic [N_GPO-1:0][PXW-1:0] gpo_px_last_i,
  output logic                      de_o,
  output logic [PXW-1:0]            px_o,
  output logic [LNW-1:0]            ln_o,
  output logic                      rev_o,
  output logic                      free_run_o,
  output logic [N_GPO-1:0]          gpo_o
);
  ptg_evt_t       evt;
  ptg_mode_e      mode;
  logic [PXW-1:0] px;
  logic [LNW-1:0] ln;
  logic           fpol;

  assign mode = sync_mode_i ? MODE_SYNC : MODE_DE;

  ptg_activity #(
    .LOSS_CLKS (LOSS_CLKS),
    .VBLANK_MIN(VBLANK_MIN)
  ) u_activity (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .de_i      (de_i),
    .hs_i      (hs_i),
    .vs_i      (vs_i),
    .evt_o     (evt),
    .free_run_o(free_run_o)
  );

  ptg_counters #(
    .H_TOTAL(H_TOTAL),
    .V_TOTAL(V_TOTAL)
  ) u_counters (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .px_o  (px),
    .ln_o  (ln),
    .fpol_o(fpol)
  );

  for (genvar k = 0; k < N_GPO; k++) begin : g_win
    ptg_window #(
      .PXW(PXW),
      .LNW(LNW)
    ) u_win (
      .px_i      (px),
      .ln_i      (ln),
      .ln_first_i(gpo_ln_first_i[k]),
      .ln_last_i (gpo_ln_last_i[k]),
      .px_first_i(gpo_px_first_i[k]),
      .px_last_i (gpo_px_last_i[k]),
      .hit_o     (gpo_o[k])
    );

    assert_empty_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpo_ln_first_i[k] > gpo_ln_last_i[k]) |-> !gpo_o[k]);
  end

  assign px_o  = px;
  assign ln_o  = ln;
  assign de_o  = (px < PXW'(H_ACTIVE)) && (ln < LNW'(V_ACTIVE));
  assign rev_o = fpol ^ (inv2_i ? ln[1] : ln[0]);

  assert_de_inside_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (ln_o < LNW'(V_ACTIVE)));
endmodule

// File: tb/tb_panel_timing_gen.sv
module tb_panel_timing_gen;
  localparam int CLK_P = 10;
  localparam int HA = 10, HT = 16, VA = 6, VT = 9;
  localparam int VBMIN = 24, LOSS = 80, NG = 4;
  localparam int PXW = $clog2(HT), LNW = $clog2(VT);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 1'b0, inv2 = 1'b0, de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [NG-1:0][LNW-1:0] g_lf, g_ll;
  logic [NG-1:0][PXW-1:0] g_pf, g_pl;
  logic de_o, rev_o, free_o;
  logic [PXW-1:0] px_o;
  logic [LNW-1:0] ln_o;
  logic [NG-1:0] gpo_o;

  int w_lf[NG] = '{1, 0, 4, VT-1};
  int w_ll[NG] = '{2, VT-1, 2, VT-1};
  int w_pf[NG] = '{3, 0, 0, HT-1};
  int w_pl[NG] = '{5, HT-1, HT-1, HT-1};

  always #(CLK_P/2) clk = ~clk;

  panel_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .inv2_i(inv2),
    .de_i(de), .hs_i(hs), .vs_i(vs),
    .gpo_ln_first_i(g_lf), .gpo_ln_last_i(g_ll),
    .gpo_px_first_i(g_pf), .gpo_px_last_i(g_pl),
    .de_o(de_o), .px_o(px_o), .ln_o(ln_o), .rev_o(rev_o),
    .free_run_o(free_o), .gpo_o(gpo_o)
  );

  // behavioural reference
  int m_px, m_ln, m_idle, m_good;
  bit m_fpol, m_free, m_deq, m_hsq, m_vsq, m_vpend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_px = 0; m_ln = 0; m_idle = 0; m_good = 0;
      m_fpol = 0; m_free = 1; m_deq = 0; m_hsq = 0; m_vsq = 0; m_vpend = 0;
    end else begin
      bit hr, vr, ev, fs, al, nl;
      hr = hs && !m_hsq;
      vr = vs && !m_vsq;
      if (sync_mode) begin ev = hr; fs = hr && (m_vpend || vr); end
      else begin ev = de && !m_deq; fs = ev && (m_idle >= VBMIN); end
      al = ev && (!m_free || m_good == 1);
      nl = 1;
      if (al) begin m_px = 0; m_ln = fs ? 0 : (m_ln + 1) % VT; end
      else if (m_px == HT - 1) begin m_px = 0; m_ln = (m_ln + 1) % VT; end
      else begin m_px++; nl = 0; end
      if (nl && m_ln == 0) m_fpol = !m_fpol;
      if (ev) begin
        m_idle = 0;
        if (m_free && m_good == 1) m_free = 0;
        if (m_good < 2) m_good++;
      end else if (m_idle == LOSS) begin
        m_free = 1; m_good = 0;
      end else m_idle++;
      m_vpend = (m_vpend || vr) && !hr;
      m_deq = de; m_hsq = hs; m_vsq = vs;
    end
  end

  int vectors = 0, miscompares = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      int r;
      chk(phase, "px", int'(px_o), m_px);
      chk(phase, "ln", int'(ln_o), m_ln);
      chk(phase, "free_run", int'(free_o), int'(m_free));
      chk("R11", "de", int'(de_o), int'(m_px < HA && m_ln < VA));
      r = int'(m_fpol) ^ ((inv2 ? (m_ln >> 1) : m_ln) & 1);
      chk(inv2 ? "R8/R9" : "R7/R9", "rev", int'(rev_o), r);
      for (int k = 0; k < NG; k++)
        chk("R10", $sformatf("gpo%0d", k), int'(gpo_o[k]),
            int'(m_ln >= w_lf[k] && m_ln <= w_ll[k] && m_px >= w_pf[k] && m_px <= w_pl[k]));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      miscompares++;
      $display("FAIL R2 watchdog cycles=%0d expected<=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); de = 0; hs = 0; vs = 0;
    end
  endtask

  task automatic drive_line(input bit act, input int vlo, input int vhi, input int base);
    for (int c = 0; c < HT; c++) begin
      @(negedge clk);
      de = act && c < HA;
      hs = c < 2;
      vs = (base + c) >= vlo && (base + c) < vhi;
    end
  endtask

  task automatic frame(input int vlo, input int vhi);
    for (int l = 0; l < VT; l++) drive_line(l < VA, vlo, vhi, l * HT);
  endtask

  initial begin
    for (int k = 0; k < NG; k++) begin
      g_lf[k] = LNW'(w_lf[k]); g_ll[k] = LNW'(w_ll[k]);
      g_pf[k] = PXW'(w_pf[k]); g_pl[k] = PXW'(w_pl[k]);
    end
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    phase = "R2";
    idle(300);
    phase = "R3";
    frame(0, 0); frame(0, 0);
    inv2 = 1'b1; phase = "R8";
    frame(0, 0); frame(0, 0);
    phase = "R5";
    idle(200);
    phase = "R6";
    drive_line(1, 0, 0, 0);
    idle(100);
    frame(0, 0); frame(0, 0);
    inv2 = 1'b0;
    // restart in sync-only mode
    phase = "R1";
    @(negedge clk); rst_n = 1'b0; de = 0; hs = 0; vs = 0;
    idle(2);
    sync_mode = 1'b1;
    rst_n = 1'b1;
    idle(20);
    phase = "R4";
    frame(0, 2 * HT); frame(0, 2 * HT);
    frame(5, 5 + 2 * HT);
    inv2 = 1'b1;
    frame(5, 5 + 2 * HT); frame(0, 2 * HT);
    phase = "R5";
    idle(150);
    phase = "R6";
    frame(0, 2 * HT); frame(0, 2 * HT);
    idle(4);
    finish_run();
  end
endmodule